// File: doc/BRIEF.md
# Byte-Lane Strobe Generator with Bus Sizing

This block sits between a processor's access requests and an external memory bus. Each request carries an address, a size, a read/write flag and a target class. The block answers with four active-low byte strobes, a mask of the data lanes that carry the transfer, and the address of the bus cycle. It also gives the requester `done`, `busy` and `err` handshakes.

A mode input selects a 32-bit or a 16-bit data bus while the block runs. On the 32-bit bus, byte lanes follow big-endian order. On the 16-bit bus only the two low strobes are used, and a longword becomes two word cycles back to back. Strobes are withheld for internal-memory targets. The lane mask and the handshakes still behave as for any other target.

Size codes: `00` byte, `01` word, `10` longword, `11` invalid. Target codes: `00` external memory, `01` on-chip peripheral, `10` internal RAM, `11` internal ROM/cache. Lane i covers data bits [8i+7:8i]. Strobe bit i belongs to lane i.

Top module: `byte_lane_strobe`

## Requirements
- R1: After synchronous reset, `bs_n` is 4'b1111, `lane_valid`, `busy`, `done` and `err` are 0, and `bus_addr` is 0.
- R2: A request is accepted at a rising edge where `req_valid` is 1 and `busy` is 0. Its first bus cycle appears in the outputs during the following cycle.
- R3: On the 32-bit bus (`bus16`=0), a byte at address bits [1:0] = 0, 1, 2, 3 drives `bs_n` to 0111, 1011, 1101, 1110 respectively.
- R4: On the 32-bit bus, a word at address bits [1:0]=00 drives `bs_n` to 0011, and a word at 10 drives it to 1100. A longword drives it to 0000.
- R5: On the 16-bit bus, an even-address byte drives `bs_n` to 1101 and an odd-address byte drives it to 1110. A word drives it to 1100.
- R6: On the 16-bit bus, a longword gives two consecutive cycles, each with `bs_n`=1100. `bus_addr` equals the request address in the first cycle and that address plus 2 in the second. `busy` is 1 only in the first cycle.
- R7: While `bus16` is 1, strobes 3 and 2 stay high in every cycle.
- R8: For targets 10 and 11, `bs_n` stays 1111. `lane_valid` still shows the lanes the access uses, and the split and `done` timing are unchanged. Targets 00 and 01 assert strobes.
- R9: Three requests are errors: a word with address bit 0 set, a longword with address bits [1:0] not 00, and size code 11. An error gives one cycle with `err`=1 and `done`=1, `bs_n`=1111 and `lane_valid`=0, and it is never split.
- R10: `done` is 1 in the single cycle of an unsplit access and in the second cycle of a split one. A request presented while `busy` is 1 is ignored.
- R11: Strobes, `lane_valid` and `done` last one cycle per bus cycle and return to idle when no new request was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus16 | input | 1 | 1 selects the 16-bit data bus, 0 the 32-bit bus |
| req_valid | input | 1 | Request present |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 2 | 00 byte, 01 word, 10 longword, 11 invalid |
| req_write | input | 1 | Write flag (passed to no strobe decision) |
| req_target | input | 2 | 00 external, 01 peripheral, 10 internal RAM, 11 internal ROM/cache |
| bs_n | output | 4 | Active-low byte strobes, bit i for lane i |
| lane_valid | output | 4 | Active-high lanes carrying data this cycle |
| bus_addr | output | ADDR_W | Address of the current bus cycle |
| busy | output | 1 | Second half of a split longword pending |
| done | output | 1 | Access completes this cycle |
| err | output | 1 | Misaligned or invalid request rejected |

## Verification
Two events can meet in one cycle: the first half of a split longword is on the bus while the requester offers a new access. The bench holds a second request valid throughout that busy cycle. It then judges three things: the second half keeps its strobes and its address plus 2, `done` appears only there, and no third bus cycle follows. A second overlap is an internal-target split under 16-bit mode, where strobe gating and cycle splitting act together. There the lanes must repeat over two cycles while every strobe stays high.

// File: rtl/byte_lane_strobe.sv
module byte_lane_strobe #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus16,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic              req_write,
  input  logic [1:0]        req_target,
  output logic [3:0]        bs_n,
  output logic [3:0]        lane_valid,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              busy,
  output logic              done,
  output logic              err
);

  localparam logic [3:0] IDLE_N = 4'b1111;
  localparam logic [3:0] LOW16  = 4'b0011;

  logic [3:0] lanes;
  logic       bad, split, gated, hold_gated;
  logic       accept;

  assign gated  = req_target inside {2'b10, 2'b11};
  assign accept = req_valid && !busy;

  always_comb begin
    lanes = 4'b0000;
    bad   = 1'b0;
    split = 1'b0;
    case (req_size)
      2'b00: lanes = bus16 ? (req_addr[0] ? 4'b0001 : 4'b0010)
                           : (4'b1000 >> req_addr[1:0]);
      2'b01: if (req_addr[0]) bad = 1'b1;
             else lanes = (bus16 || req_addr[1]) ? LOW16 : 4'b1100;
      2'b10: if (|req_addr[1:0]) bad = 1'b1;
             else begin
               lanes = bus16 ? LOW16 : 4'b1111;
               split = bus16;
             end
      default: bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bs_n       <= IDLE_N;
      lane_valid <= 4'b0000;
      bus_addr   <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      err        <= 1'b0;
      hold_gated <= 1'b0;
    end else begin
      bs_n       <= IDLE_N;
      lane_valid <= 4'b0000;
      done       <= 1'b0;
      err        <= 1'b0;
      if (busy) begin
        bs_n       <= hold_gated ? IDLE_N : ~LOW16;
        lane_valid <= LOW16;
        bus_addr   <= bus_addr + ADDR_W'(2);
        busy       <= 1'b0;
        done       <= 1'b1;
      end else if (accept) begin
        bus_addr <= req_addr;
        done     <= !split || bad;
        if (bad) begin
          err <= 1'b1;
        end else begin
          lane_valid <= lanes;
          bs_n       <= gated ? IDLE_N : ~lanes;
          busy       <= split;
          hold_gated <= gated;
        end
      end
    end
  end

  logic unused_ok;
  assign unused_ok = req_write;

  a_r7_upper_high_16: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(bus16)) |-> (bs_n[3:2] == 2'b11));

  a_r9_err_no_strobe: assert property (@(posedge clk) disable iff (rst)
    err |-> (bs_n == 4'b1111 && lane_valid == 4'b0000 && done && !busy));

  a_r6_busy_then_done: assert property (@(posedge clk) disable iff (rst)
    busy |=> (done && !busy && bs_n[3:2] == 2'b11));

  a_r10_no_done_while_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> (!done && !err));

  a_r8_internal_gated: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy && req_target[1]) |=> (bs_n == 4'b1111));

  a_r11_strobe_in_lane: assert property (@(posedge clk) disable iff (rst)
    ((~bs_n & ~lane_valid) == 4'b0000));

endmodule

// File: tb/tb_byte_lane_strobe.sv
module tb_byte_lane_strobe;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bus16 = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'b00;
  logic          req_write = 1'b0;
  logic [1:0]    req_target = 2'b00;
  logic [3:0]    bs_n, lane_valid;
  logic [AW-1:0] bus_addr;
  logic          busy, done, err;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  byte_lane_strobe #(.ADDR_W(AW)) dut (
    .clk(clk), .rst(rst), .bus16(bus16), .req_valid(req_valid),
    .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
    .req_target(req_target), .bs_n(bs_n), .lane_valid(lane_valid),
    .bus_addr(bus_addr), .busy(busy), .done(done), .err(err));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: {bs_n,lanes,busy,done,err}+pad actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] pack(input logic [3:0] b, input logic [3:0] l,
                                        input logic bz, input logic d, input logic e);
    return {b, l, bz, d, e, 1'b0};
  endfunction

  function automatic logic [11:0] now();
    return {bs_n, lane_valid, busy, done, err, 1'b0};
  endfunction

  task automatic check_addr(input string tag, input logic [AW-1:0] exp);
    n_checks++;
    if (bus_addr !== exp) begin
      n_fail++;
      $display("FAIL %s: bus_addr actual=%h expected=%h", tag, bus_addr, exp);
    end
  endtask

  task automatic issue(input logic m16, input logic [AW-1:0] a, input logic [1:0] sz,
                       input logic [1:0] tg);
    @(negedge clk);
    bus16 = m16; req_addr = a; req_size = sz; req_target = tg; req_valid = 1'b1;
    req_write = a[2];
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset outputs", now(), pack(4'b1111, 4'b0000, 0, 0, 0));
    check_addr("R1 reset addr", '0);
  endtask

  task automatic t_bytes32();
    for (int a = 0; a < 4; a++) begin
      logic [3:0] l;
      l = 4'b1000 >> a;
      issue(0, AW'(32'h100 + a), 2'b00, 2'b00);
      check("R3 R2 byte32", now(), pack(~l, l, 0, 1, 0));
      check_addr("R2 byte32 addr", AW'(32'h100 + a));
    end
    @(negedge clk);
    check("R11 idle after byte", now(), pack(4'b1111, 4'b0000, 0, 0, 0));
  endtask

  task automatic t_words32();
    issue(0, 32'h200, 2'b01, 2'b00);
    check("R4 word32 a0", now(), pack(4'b0011, 4'b1100, 0, 1, 0));
    issue(0, 32'h202, 2'b01, 2'b01);
    check("R4 word32 a2 periph", now(), pack(4'b1100, 4'b0011, 0, 1, 0));
    issue(0, 32'h204, 2'b10, 2'b00);
    check("R4 long32", now(), pack(4'b0000, 4'b1111, 0, 1, 0));
  endtask

  task automatic t_16bit();
    issue(1, 32'h300, 2'b00, 2'b00);
    check("R5 R7 byte16 even", now(), pack(4'b1101, 4'b0010, 0, 1, 0));
    issue(1, 32'h303, 2'b00, 2'b00);
    check("R5 R7 byte16 odd", now(), pack(4'b1110, 4'b0001, 0, 1, 0));
    issue(1, 32'h306, 2'b01, 2'b01);
    check("R5 R7 word16", now(), pack(4'b1100, 4'b0011, 0, 1, 0));
  endtask

  task automatic t_split();
    issue(1, 32'h410, 2'b10, 2'b00);
    req_valid = 1'b1; bus16 = 1'b0; req_addr = 32'h501; req_size = 2'b00;
    check("R6 R10 split beat1", now(), pack(4'b1100, 4'b0011, 1, 0, 0));
    check_addr("R6 beat1 addr", 32'h410);
    @(negedge clk);
    req_valid = 1'b0;
    check("R6 R10 split beat2", now(), pack(4'b1100, 4'b0011, 0, 1, 0));
    check_addr("R6 beat2 addr", 32'h412);
    @(negedge clk);
    check("R10 R11 request during busy ignored", now(), pack(4'b1111, 4'b0000, 0, 0, 0));
  endtask

  task automatic t_gating();
    issue(0, 32'h600, 2'b10, 2'b01);
    check("R8 peripheral long", now(), pack(4'b0000, 4'b1111, 0, 1, 0));
    issue(0, 32'h600, 2'b10, 2'b10);
    check("R8 internal long32", now(), pack(4'b1111, 4'b1111, 0, 1, 0));
    issue(0, 32'h601, 2'b00, 2'b11);
    check("R8 internal byte", now(), pack(4'b1111, 4'b0100, 0, 1, 0));
    issue(1, 32'h608, 2'b10, 2'b11);
    check("R8 internal split beat1", now(), pack(4'b1111, 4'b0011, 1, 0, 0));
    @(negedge clk);
    check("R8 internal split beat2", now(), pack(4'b1111, 4'b0011, 0, 1, 0));
    check_addr("R8 internal split addr", 32'h60A);
  endtask

  task automatic t_misalign();
    issue(0, 32'h701, 2'b01, 2'b00);
    check("R9 word odd", now(), pack(4'b1111, 4'b0000, 0, 1, 1));
    @(negedge clk);
    check("R9 err one cycle", now(), pack(4'b1111, 4'b0000, 0, 0, 0));
    issue(1, 32'h702, 2'b10, 2'b00);
    check("R9 long misaligned no split", now(), pack(4'b1111, 4'b0000, 0, 1, 1));
    issue(0, 32'h704, 2'b11, 2'b00);
    check("R9 size code 11", now(), pack(4'b1111, 4'b0000, 0, 1, 1));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_bytes32();
    t_words32();
    t_16bit();
    t_split();
    t_gating();
    t_misalign();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule